// File: doc/BRIEF.md
# Shared Memory Port Hazard Arbiter

This block lets a pipelined processor use a memory that has only one access port. Two stages compete for that port. The instruction-fetch stage asks for a read on nearly every cycle. The memory-access stage asks only when its instruction is a load or a store. Each cycle the arbiter picks one of them to drive the port. It routes that side's address, write data and write enable, and it tells the other side to wait.

The data side always wins a conflict, because its instruction is older and must make progress. When fetch loses, the arbiter raises a stall output for that cycle. The pipeline uses it to hold the program counter, freeze the front stages and insert a bubble. The arbiter also keeps the denied fetch pending, with the address it had when first refused. It serves that fetch on the first cycle with no data request, even if the fetch stage has dropped its request in the meantime. Such stalls happen even between instructions that share no register and no branch; port contention alone causes them.

Top module: `memport_arbiter`

## Requirements
- R1: A data request (`dm_req`=1) is granted in the same cycle without exception: `dm_gnt` equals `dm_req`.
- R2: When there is no data request and no fetch is pending, a fetch request is granted in the same cycle, and `mem_addr` equals `fe_addr`.
- R3: When fetch and data both want the port, the port carries the data side's address, and `fe_gnt` is 0.
- R4: `fe_stall` is 1 exactly in the cycles where a fetch demand (a new or pending request) is refused because of a data request.
- R5: `fe_gnt` and `dm_gnt` are never both 1 in one cycle.
- R6: `mem_we` is 1 only when the data side holds the grant and `dm_we`=1. While fetch holds the grant, `mem_we`=0 and `mem_wdata`=0, whatever the data-side inputs are.
- R7: A refused fetch stays pending until it is granted, even if `fe_req` drops. It is served on the first cycle with no data request, using the address captured at the first refusal, and then it clears.
- R8: Synchronous active-high `rst` clears the pending fetch. After reset, with both requests low, all grants, `fe_stall`, `mem_en` and `mem_we` are 0.
- R9: `mem_en` is 1 in a cycle exactly when some side is granted the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_req | input | 1 | Fetch read request |
| fe_addr | input | AW | Fetch address |
| fe_gnt | output | 1 | Fetch owns the port this cycle |
| fe_stall | output | 1 | Fetch refused; freeze the front stages and insert a bubble |
| dm_req | input | 1 | Data request, from a load or a store |
| dm_we | input | 1 | Data request is a store |
| dm_addr | input | AW | Data address |
| dm_wdata | input | DW | Store data |
| dm_gnt | output | 1 | Data side owns the port this cycle |
| mem_en | output | 1 | Port access enable |
| mem_we | output | 1 | Port write enable |
| mem_addr | output | AW | Port address |
| mem_wdata | output | DW | Port write data |

## Verification
A fetch and a load or store can land in the same cycle. The bench causes this by holding `fe_req` high while it drives `dm_req`. It checks that the port shows the data address, that `fe_stall` rises, and that no second grant appears. The bench then removes the data request, with and without `fe_req` still high. It checks that the held fetch address reaches the port exactly once. Reset is also applied while a fetch is pending, and the bench checks that nothing pending survives.

// File: rtl/memport_arbiter.sv
module memport_arbiter #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fe_req,
  input  logic [AW-1:0] fe_addr,
  output logic          fe_gnt,
  output logic          fe_stall,
  input  logic          dm_req,
  input  logic          dm_we,
  input  logic [AW-1:0] dm_addr,
  input  logic [DW-1:0] dm_wdata,
  output logic          dm_gnt,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);

  logic          pend_q;
  logic [AW-1:0] pend_addr_q;
  logic          fe_want;
  logic [AW-1:0] fe_eff_addr;

  assign fe_want     = fe_req | pend_q;
  assign fe_eff_addr = pend_q ? pend_addr_q : fe_addr;

  assign dm_gnt   = dm_req;
  assign fe_gnt   = fe_want & ~dm_req;
  assign fe_stall = fe_want & dm_req;

  assign mem_en    = dm_gnt | fe_gnt;
  assign mem_we    = dm_gnt & dm_we;
  assign mem_addr  = dm_gnt ? dm_addr : fe_eff_addr;
  assign mem_wdata = dm_gnt ? dm_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else if (fe_stall) begin
      pend_q <= 1'b1;
      if (!pend_q) pend_addr_q <= fe_addr;
    end else if (fe_gnt) begin
      pend_q <= 1'b0;
    end
  end

  p_data_first_r1: assert property (@(posedge clk) disable iff (rst)
    dm_req |-> (dm_gnt && !fe_gnt));

  p_zero_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (fe_req && !dm_req && !fe_stall && !$past(fe_stall)) |-> (fe_gnt && mem_addr == fe_addr));

  p_conflict_port_r3: assert property (@(posedge clk) disable iff (rst)
    (fe_req && dm_req) |-> (mem_addr == dm_addr && !fe_gnt));

  p_stall_denied_r4: assert property (@(posedge clk) disable iff (rst)
    fe_stall |-> (!fe_gnt && dm_gnt));

  p_one_grant_r5: assert property (@(posedge clk) disable iff (rst)
    !(fe_gnt && dm_gnt));

  p_store_owner_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (dm_gnt && dm_we));

  p_fetch_held_r7: assert property (@(posedge clk) disable iff (rst)
    fe_stall |=> (fe_gnt || fe_stall));

  p_enable_r9: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> (fe_gnt || dm_gnt));

endmodule

// File: tb/memport_arbiter_tb_top.sv
module memport_arbiter_tb_top;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NV = 9;

  logic          clk = 1'b0;
  logic          rst;
  logic          fe_req, dm_req, dm_we;
  logic [AW-1:0] fe_addr, dm_addr;
  logic [DW-1:0] dm_wdata;
  logic          fe_gnt, fe_stall, dm_gnt, mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  memport_arbiter #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst),
    .fe_req(fe_req), .fe_addr(fe_addr), .fe_gnt(fe_gnt), .fe_stall(fe_stall),
    .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .dm_gnt(dm_gnt), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // stimulus {fe_req, fe_addr, dm_req, dm_we, dm_addr, dm_wdata}
  // expected {fe_gnt, dm_gnt, fe_stall, mem_en, mem_we, mem_addr, mem_wdata}
  localparam logic [47:0] VEC [NV] = '{
    {1'b1, 8'h10, 1'b0, 1'b0, 8'h00, 8'h00,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h10, 8'h00},
    {1'b1, 8'h14, 1'b1, 1'b0, 8'h80, 8'h00,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h80, 8'h00},
    {1'b1, 8'h14, 1'b1, 1'b1, 8'h84, 8'hAA,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h84, 8'hAA},
    {1'b1, 8'h14, 1'b0, 1'b0, 8'h00, 8'h00,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h14, 8'h00},
    {1'b0, 8'h00, 1'b1, 1'b1, 8'h90, 8'h55,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h90, 8'h55},
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00},
    {1'b1, 8'h20, 1'b1, 1'b0, 8'h40, 8'h00,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h40, 8'h00},
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h20, 8'h00},
    {1'b1, 8'h24, 1'b0, 1'b1, 8'h77, 8'hFF,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h24, 8'h00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic fr, input logic [7:0] fa, input logic dr,
                       input logic dw, input logic [7:0] da, input logic [7:0] wd);
    fe_req = fr; fe_addr = fa; dm_req = dr; dm_we = dw; dm_addr = da; dm_wdata = wd;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(0, 0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R8 reset grants/stall", {28'd0, fe_gnt, dm_gnt, fe_stall, mem_en}, 32'd0);
    check("R8 reset we", {31'd0, mem_we}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      v = VEC[i];
      @(negedge clk);
      drive(v[47], v[46:39], v[38], v[37], v[36:29], v[28:21]);
      #1;
      check($sformatf("R1 dm_gnt v%0d", i), {31'd0, dm_gnt}, {31'd0, v[19]});
      check($sformatf("R2 R3 R7 fe_gnt v%0d", i), {31'd0, fe_gnt}, {31'd0, v[20]});
      check($sformatf("R4 fe_stall v%0d", i), {31'd0, fe_stall}, {31'd0, v[18]});
      check($sformatf("R5 one grant v%0d", i), {31'd0, fe_gnt & dm_gnt}, 32'd0);
      check($sformatf("R9 mem_en v%0d", i), {31'd0, mem_en}, {31'd0, v[17]});
      check($sformatf("R6 mem_we v%0d", i), {31'd0, mem_we}, {31'd0, v[16]});
      check($sformatf("R3 R7 mem_addr v%0d", i), {24'd0, mem_addr}, {24'd0, v[15:8]});
      check($sformatf("R6 mem_wdata v%0d", i), {24'd0, mem_wdata}, {24'd0, v[7:0]});
    end

    // R7: long run of data cycles, held address survives a changing fe_addr
    @(negedge clk); drive(1, 8'h30, 1, 0, 8'h50, 0);
    @(negedge clk); drive(1, 8'h31, 1, 1, 8'h51, 8'h11);
    @(negedge clk); drive(1, 8'h32, 1, 0, 8'h52, 0);
    #1;
    check("R4 stall during run", {31'd0, fe_stall}, 32'd1);
    @(negedge clk); drive(1, 8'h33, 0, 0, 0, 0);
    #1;
    check("R7 held addr served", {24'd0, mem_addr}, 32'h30);
    check("R7 held grant", {31'd0, fe_gnt}, 32'd1);
    @(negedge clk);
    #1;
    check("R7 pending cleared", {24'd0, mem_addr}, 32'h33);

    // R8: reset clears pending fetch
    @(negedge clk); drive(1, 8'h60, 1, 0, 8'h70, 0);
    @(negedge clk); rst = 1'b1; drive(0, 0, 0, 0, 0, 0);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R8 no pending after reset", {28'd0, fe_gnt, dm_gnt, fe_stall, mem_en}, 32'd0);
    @(negedge clk); drive(1, 8'h61, 0, 0, 0, 0);
    #1;
    check("R8 R2 fresh address after reset", {24'd0, mem_addr}, 32'h61);

    @(negedge clk); drive(0, 0, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule